// File: doc/BRIEF.md
# NAND Flash Host Interface

This block is a bus slave that gives a processor direct control of a raw 8-bit NAND flash device through a 4 KB address window. The lower half of the window is a data window. Every byte access to any address in it runs exactly one NAND data cycle: a read strobe for a load and a write strobe for a store. Software can therefore stream a whole 2 KB page through consecutive addresses. Data-window accesses stall the bus until the strobe has completed.

The upper half holds three registers. A control register sets the chip-enable, command-latch and address-latch pin levels. A command/address register launches one write cycle that carries the byte using the latch levels currently held in the control register. A status register reports the synchronized flash ready pin, the controller's busy flag and a sticky completion flag. Command/address writes are posted. Software is expected to poll the busy flag first, and a write that arrives while a cycle is running is dropped whole.

Top module: `nand_host`

## Requirements
- R1: After reset: ceN=1, cle=0, ale=0, weN=1, reN=1, ioOe=0. The control register reads 0x01. The status register shows busy=0 and done=0.
- R2: A store to any offset 0x000–0x7FF runs one write strobe with the stored byte on ioOut. busAck pulses for one cycle after the strobe has returned high.
- R3: A load from any offset 0x000–0x7FF runs one read strobe. It returns the byte present on ioIn during the final low clock of reN. ioOe stays low throughout.
- R4: The control register sits at offset 0x800. Bit0 is the raw ceN pin level (0 selects the device), bit1 drives cle, bit2 drives ale, and bits 3 and 4 are stored flags. Bits 7:5 read as zero.
- R5: A store to offset 0x801 while idle is acknowledged at once. It launches one write strobe carrying the byte, with cle/ale equal to control bits 1 and 2 as they were at launch.
- R6: Each strobe is low for LOW_CLKS clocks (default 2) and then high for HIGH_CLKS clocks (default 2). ioOut, cle and ale stay stable while the strobe is low, and weN and reN are never low together.
- R7: The status register sits at offset 0x810. Bit3 is the ready pin rbN after a two-flop synchronizer, bit2 is busy, bit1 is done, and bit0 reads 0.
- R8: Busy is 1 from the first low clock of a strobe until the end of its high phase, and 0 otherwise.
- R9: A store to offset 0x801 while busy is acknowledged but ignored. It produces no strobe and does not change the byte being driven.
- R10: Done sets when a 0x801 cycle finishes. It clears when the status register is read, and that read still returns done=1.
- R11: A data-window access issued while a 0x801 cycle is running waits until that cycle ends and is then performed in order.
- R12: Other offsets read as zero, and stores to them have no effect on the pins or the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Access request, held until busAck |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | 12 | Byte offset in the window |
| busWdata | input | 8 | Store data |
| busRdata | output | 8 | Load data, valid with busAck |
| busAck | output | 1 | One-cycle completion pulse |
| ceN | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Byte driven to the flash |
| ioOe | output | 1 | Output enable for ioOut |
| ioIn | input | 8 | Byte returned by the flash |
| rbN | input | 1 | Flash ready (1) / busy (0) |

## Verification
A corrupted sequencer state shows up on the strobe pins within one strobe period. It appears as a low phase of the wrong length, a second strobe after a dropped command write, or a missing bus acknowledge that stalls a data-window access. Wrong latching of the command levels or the byte appears at the rising strobe edge, where the bench's flash model records cle, ale and ioOut. A stale or wrongly cleared completion flag shows on the next two status reads. A synchronizer fault shows as a ready bit that does not follow rbN within three clocks.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  // control register bit positions (software decodes these)
  localparam int CTL_W   = 5;
  localparam int CTL_CE  = 0;
  localparam int CTL_CLE = 1;
  localparam int CTL_ALE = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} seqState_e;

  typedef enum logic [1:0] {RS_ZERO, RS_CTL, RS_STS, RS_DATA} rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   ctlWrite;
    logic   launch;
    logic   launchRead;
    logic   capture;
    logic   statusRead;
    logic   ioDone;
    logic   ackLoad;
    rdSel_e rdSel;
    logic   active;
    logic   stbLow;
    logic   isRead;
  } hostStb_t;

endpackage

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nand_host_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LOW_CLKS  = 2,
  parameter int HIGH_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output hostStb_t          stb
);

  localparam int MAX_CLKS = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] CTL_OFS  = WIN_SIZE;
  localparam logic [ADDR_W-1:0] CMD_OFS  = WIN_SIZE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STS_OFS  = WIN_SIZE + ADDR_W'(16);
  localparam logic [CNT_W-1:0]  LOW_LAST  = CNT_W'(LOW_CLKS - 1);
  localparam logic [CNT_W-1:0]  HIGH_LAST = CNT_W'(HIGH_CLKS - 1);

  seqState_e  state;
  logic [CNT_W-1:0] cnt;
  logic       isReadQ;
  logic       isCmdQ;
  logic       ackQ;

  logic accept, inWin, hitCtl, hitCmd, hitSts, lowEnd, highEnd;

  assign accept  = busReq && !ackQ;
  assign inWin   = (busAddr < WIN_SIZE);
  assign hitCtl  = (busAddr == CTL_OFS);
  assign hitCmd  = (busAddr == CMD_OFS);
  assign hitSts  = (busAddr == STS_OFS);
  assign lowEnd  = (state == ST_LOW)  && (cnt == LOW_LAST);
  assign highEnd = (state == ST_HIGH) && (cnt == HIGH_LAST);
  assign busAck  = ackQ;

  always_comb begin
    stb        = '0;
    stb.active = (state != ST_IDLE);
    stb.stbLow = (state == ST_LOW);
    stb.isRead = isReadQ;
    stb.capture = lowEnd && isReadQ;
    stb.ioDone  = highEnd && isCmdQ;
    if (accept) begin
      if (inWin) begin
        // data window: held until the sequencer is idle
        if (state == ST_IDLE) begin
          stb.launch     = 1'b1;
          stb.launchRead = !busWrite;
        end
      end else begin
        stb.ackLoad = 1'b1;
        if (hitCtl) begin
          stb.rdSel    = RS_CTL;
          stb.ctlWrite = busWrite;
        end else if (hitSts) begin
          stb.rdSel      = RS_STS;
          stb.statusRead = !busWrite;
        end else if (hitCmd && busWrite && state == ST_IDLE) begin
          stb.launch = 1'b1;
        end
      end
    end
    if (highEnd && !isCmdQ) begin
      stb.ackLoad = 1'b1;
      stb.rdSel   = RS_DATA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isReadQ <= 1'b0;
      isCmdQ  <= 1'b0;
      ackQ    <= 1'b0;
    end else begin
      ackQ <= stb.ackLoad;
      unique case (state)
        ST_IDLE: begin
          if (stb.launch) begin
            state   <= ST_LOW;
            cnt     <= '0;
            isReadQ <= stb.launchRead;
            isCmdQ  <= !inWin;
          end
        end
        ST_LOW: begin
          if (lowEnd) begin
            state <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (highEnd) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            isReadQ <= 1'b0;
            isCmdQ  <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_host_dp.sv
module nand_host_dp
  import nand_host_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ioIn,
  input  logic              rbN,
  output logic [DATA_W-1:0] busRdata,
  output logic              ceN,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [DATA_W-1:0] ioOut,
  output logic              ioOe,
  output logic              busyFlag
);

  logic [CTL_W-1:0]  ctlReg;
  logic [DATA_W-1:0] outLatch;
  logic [DATA_W-1:0] inLatch;
  logic              cleLat, aleLat;
  logic              doneFlag;
  logic [SYNC_STAGES-1:0] syncQ;
  logic              flashReady;
  logic [DATA_W-1:0] ctlView, stsView, rdNext;

  // ready pin synchronizer
  for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[gi] <= 1'b0;
      else if (gi == 0) syncQ[gi] <= rbN;
      else syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi - 1];
    end
  end
  assign flashReady = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg   <= CTL_W'(1);
      outLatch <= '0;
      inLatch  <= '0;
      cleLat   <= 1'b0;
      aleLat   <= 1'b0;
      doneFlag <= 1'b0;
      busRdata <= '0;
    end else begin
      if (stb.ctlWrite) ctlReg <= busWdata[CTL_W-1:0];
      if (stb.launch) begin
        outLatch <= busWdata;
        cleLat   <= ctlReg[CTL_CLE];
        aleLat   <= ctlReg[CTL_ALE];
      end
      if (stb.capture) inLatch <= ioIn;
      if (stb.ioDone) doneFlag <= 1'b1;
      else if (stb.statusRead) doneFlag <= 1'b0;
      if (stb.ackLoad) busRdata <= rdNext;
    end
  end

  assign ctlView = {{(DATA_W - CTL_W){1'b0}}, ctlReg};
  assign stsView = {{(DATA_W - 4){1'b0}}, flashReady, stb.active, doneFlag, 1'b0};

  always_comb begin
    unique case (stb.rdSel)
      RS_CTL:  rdNext = ctlView;
      RS_STS:  rdNext = stsView;
      RS_DATA: rdNext = stb.isRead ? (stb.capture ? ioIn : inLatch) : '0;
      default: rdNext = '0;
    endcase
  end

  assign busyFlag = stb.active;
  assign ceN   = ctlReg[CTL_CE];
  assign cle   = stb.active ? cleLat : ctlReg[CTL_CLE];
  assign ale   = stb.active ? aleLat : ctlReg[CTL_ALE];
  assign weN   = !(stb.stbLow && !stb.isRead);
  assign reN   = !(stb.stbLow && stb.isRead);
  assign ioOe  = stb.active && !stb.isRead;
  assign ioOut = outLatch;

endmodule

// File: rtl/nand_host.sv
module nand_host
  import nand_host_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int LOW_CLKS    = 2,
  parameter int HIGH_CLKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busAck,
  output logic              ceN,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [DATA_W-1:0] ioOut,
  output logic              ioOe,
  input  logic [DATA_W-1:0] ioIn,
  input  logic              rbN
);

  hostStb_t stb;
  logic     busyFlag;

  nand_host_ctrl #(
    .ADDR_W(ADDR_W), .LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busAck(busAck), .stb(stb)
  );

  nand_host_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .ioIn(ioIn),
    .rbN(rbN), .busRdata(busRdata), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .ioOut(ioOut), .ioOe(ioOe), .busyFlag(busyFlag)
  );

endmodule

// File: rtl/nand_host_chk.sv
module nand_host_chk #(
  parameter int DATA_W   = 8,
  parameter int LOW_CLKS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              weN,
  input logic              reN,
  input logic              ioOe,
  input logic              busAck,
  input logic              cle,
  input logic              ale,
  input logic [DATA_W-1:0] ioOut,
  input logic              busyFlag
);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    weN || reN);

  p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !ioOe);

  p_hold_while_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && $past(!weN)) |-> ($stable(ioOut) && $stable(cle) && $stable(ale)));

  p_busy_covers_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !reN) |-> busyFlag);

  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  p_low_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((LOW_CLKS > 1) && $fell(weN)) |=> !weN);

endmodule

bind nand_host nand_host_chk #(.DATA_W(DATA_W), .LOW_CLKS(LOW_CLKS)) uChk (
  .clk(clk), .rstN(rstN), .weN(weN), .reN(reN), .ioOe(ioOe),
  .busAck(busAck), .cle(cle), .ale(ale), .ioOut(ioOut), .busyFlag(busyFlag)
);

// File: tb/nand_host_test.sv
`timescale 1ns/1ps
module nand_host_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReq = 1'b0;
  logic       busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       busAck;
  logic       ceN, cle, ale, weN, reN, ioOe;
  logic [7:0] ioOut;
  logic [7:0] ioIn;
  logic       rbN = 1'b1;
  logic [7:0] flashByte = 8'h00;

  int checks = 0;
  int fails  = 0;

  // flash model logs every rising write strobe
  logic       logOn = 1'b0;
  int         logN = 0;
  int         reCount = 0;
  int         lowRun = 0;
  logic [7:0] logData [0:31];
  logic       logCle  [0:31];
  logic       logAle  [0:31];
  int         logWidth[0:31];

  always #2.5 clk = ~clk;

  assign ioIn = reN ? 8'h00 : flashByte;

  nand_host uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rbN(rbN)
  );

  always @(negedge clk) if (!weN) lowRun++;

  always @(posedge weN) begin
    if (logOn && logN < 32) begin
      logData[logN]  = ioOut;
      logCle[logN]   = cle;
      logAle[logN]   = ale;
      logWidth[logN] = lowRun;
      logN++;
    end
    lowRun = 0;
  end

  always @(negedge reN) if (logOn) reCount++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a,
                      input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    do @(negedge clk); while (!busAck);
    q = busRdata;
    busReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R1 ceN", ceN, 1); chk("R1 cle", cle, 0); chk("R1 ale", ale, 0);
    chk("R1 weN", weN, 1); chk("R1 reN", reN, 1); chk("R1 ioOe", ioOe, 0);
    xfer(1'b0, 12'h800, 8'h00, q); chk("R1 control", q, 8'h01);
    xfer(1'b0, 12'h810, 8'h00, q); chk("R1 status", q, 8'h08);
  endtask

  task automatic t_control();
    logic [7:0] q;
    xfer(1'b1, 12'h800, 8'h1E, q);
    xfer(1'b0, 12'h800, 8'h00, q); chk("R4 readback", q, 8'h1E);
    chk("R4 ceN", ceN, 0); chk("R4 cle", cle, 1); chk("R4 ale", ale, 1);
    xfer(1'b1, 12'h800, 8'hFF, q);
    xfer(1'b0, 12'h800, 8'h00, q); chk("R4 upper zero", q, 8'h1F);
    chk("R4 ceN high", ceN, 1);
  endtask

  task automatic t_cmd();
    logic [7:0] q;
    int base = logN;
    xfer(1'b1, 12'h800, 8'h02, q);
    xfer(1'b1, 12'h801, 8'h90, q);
    xfer(1'b0, 12'h810, 8'h00, q); chk("R8 busy during cycle", q & 8'h04, 8'h04);
    idle(8);
    chk("R5 one strobe", logN - base, 1);
    chk("R5 byte", logData[base], 8'h90);
    chk("R5 cle", logCle[base], 1); chk("R5 ale", logAle[base], 0);
    chk("R6 low width", logWidth[base], 2);
    xfer(1'b0, 12'h810, 8'h00, q); chk("R10 done set", q, 8'h0A);
    xfer(1'b0, 12'h810, 8'h00, q); chk("R10 done cleared", q, 8'h08);
  endtask

  task automatic t_cmdBusy();
    logic [7:0] q;
    int base = logN;
    xfer(1'b1, 12'h801, 8'hA5, q);
    xfer(1'b1, 12'h801, 8'h3C, q);
    idle(10);
    chk("R9 single strobe", logN - base, 1);
    chk("R9 byte kept", logData[base], 8'hA5);
    chk("R9 pins idle", weN, 1);
    xfer(1'b0, 12'h810, 8'h00, q);
  endtask

  task automatic t_winWrite();
    logic [7:0] q;
    int base = logN;
    xfer(1'b1, 12'h800, 8'h00, q);
    xfer(1'b1, 12'h000, 8'h11, q);
    chk("R2 strobe done at ack", logN - base, 1);
    xfer(1'b1, 12'h7FF, 8'h22, q);
    chk("R2 two strobes", logN - base, 2);
    chk("R2 byte a", logData[base], 8'h11);
    chk("R2 byte b", logData[base+1], 8'h22);
    chk("R2 cle low", logCle[base+1], 0);
    chk("R6 window width", logWidth[base+1], 2);
  endtask

  task automatic t_winRead();
    logic [7:0] q;
    int base = reCount;
    flashByte = 8'h5A;
    xfer(1'b0, 12'h123, 8'h00, q); chk("R3 data", q, 8'h5A);
    flashByte = 8'hC3;
    xfer(1'b0, 12'h7FF, 8'h00, q); chk("R3 data top", q, 8'hC3);
    chk("R3 strobes", reCount - base, 2);
    chk("R3 no drive", ioOe, 0);
  endtask

  task automatic t_queue();
    logic [7:0] q;
    int base = logN;
    xfer(1'b1, 12'h800, 8'h04, q);
    xfer(1'b1, 12'h801, 8'h01, q);
    xfer(1'b1, 12'h010, 8'h77, q);
    chk("R11 both done", logN - base, 2);
    chk("R11 order cmd", logData[base], 8'h01);
    chk("R11 order data", logData[base+1], 8'h77);
    chk("R11 ale", logAle[base], 1);
    xfer(1'b0, 12'h810, 8'h00, q);
    xfer(1'b1, 12'h800, 8'h00, q);
  endtask

  task automatic t_ready();
    logic [7:0] q;
    rbN = 1'b0; idle(3);
    xfer(1'b0, 12'h810, 8'h00, q); chk("R7 not ready", q, 8'h00);
    rbN = 1'b1; idle(3);
    xfer(1'b0, 12'h810, 8'h00, q); chk("R7 ready", q, 8'h08);
  endtask

  task automatic t_unused();
    logic [7:0] q;
    int base = logN;
    xfer(1'b1, 12'h805, 8'hFF, q);
    xfer(1'b1, 12'hFFF, 8'hFF, q);
    xfer(1'b0, 12'h800, 8'h00, q); chk("R12 control intact", q, 8'h00);
    xfer(1'b0, 12'h900, 8'h00, q); chk("R12 read zero", q, 8'h00);
    xfer(1'b0, 12'h801, 8'h00, q); chk("R12 cmd reads zero", q, 8'h00);
    idle(6);
    chk("R12 no strobe", logN - base, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(3);
    logOn = 1'b1;
    t_reset();
    t_control();
    t_cmd();
    t_cmdBusy();
    t_winWrite();
    t_winRead();
    t_queue();
    t_ready();
    t_unused();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule